// File: doc/BRIEF.md
# Strobe/Acknowledge Parallel Receive Port

This block receives parallel words from a peripheral over a strobe line, an acknowledge line and a data bus. It delivers each received word to the host over a valid/ready interface. A mode input picks one of two protocols.

In single-handshake mode a rising strobe means the data is already on the bus. The port captures the word at once and then raises acknowledge for a fixed number of cycles to signal that the transfer is complete. In double-handshake mode the first rising strobe opens a session. The port answers by raising acknowledge, which tells the peripheral that the receiver is ready. The peripheral then drives its data, and a second rising strobe closes the session: the port samples the bus on that edge and drops acknowledge.

The strobe passes through a two-flop synchroniser, and only rising edges of the synchronised strobe count. Nothing new starts while a captured word still waits for the host; busy stays high during that time and any strobe edge that arrives is discarded.

The control state machine has three states:
- `HS_IDLE`: waiting for a strobe edge.
- `HS_PULSE`: the single-mode acknowledge pulse.
- `HS_ARMED`: the double-mode ready phase.

It has four transitions:
- IDLE→PULSE: a strobe edge in single mode with no word pending; the word is captured on this transition.
- IDLE→ARMED: a strobe edge in double mode with no word pending.
- PULSE→IDLE: the pulse count is complete.
- ARMED→IDLE: the second strobe edge; the word is captured on this transition.

Top module: `strobe_ack_rx`

## Requirements
- R1: A synchronous reset, taken at a clock edge, puts the port in idle with `ack_out`, `busy` and `out_valid` all low. This also applies in the middle of a session.
- R2: The port acts only on a rising edge of `stb_in` after two synchroniser flops. If `stb_in` rises just after clock edge k, the port responds at edge k+3. Holding `stb_in` high does not start another session.
- R3: In single mode (`mode_double`=0), `data_in` is captured at the same edge that raises `ack_out`. `out_valid` goes high with that word, and later changes on `data_in` do not alter `out_data`.
- R4: In single mode, `ack_out` stays high for exactly ACK_CYCLES clock cycles (default 2) and then falls.
- R5: In double mode (`mode_double`=1), the first strobe edge raises `ack_out` while `out_valid` stays low. `ack_out` stays high until a further strobe edge arrives.
- R6: In double mode, the second strobe edge samples `data_in`. At that same edge `ack_out` falls and `out_valid` rises, carrying the sampled word.
- R7: `out_valid` and `out_data` hold steady until `out_ready` is seen high at a clock edge. `out_valid` is low after that edge.
- R8: While a word is pending, strobe edges are ignored: `ack_out` stays low, `out_data` is unchanged, and the lost edge does not start a session after the host takes the word.
- R9: `busy` is high from the start of a session until the port is idle with no word pending. It is low otherwise.
- R10: `mode_double` is sampled only at the start of a session. Changing it mid-session changes neither the protocol nor the acknowledge pulse length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_double | input | 1 | 0 = single handshake, 1 = double handshake |
| stb_in | input | 1 | Peripheral strobe, active high, asynchronous |
| data_in | input | DATA_W | Peripheral data bus |
| ack_out | output | 1 | Acknowledge to the peripheral, active high |
| busy | output | 1 | Session in progress or word pending |
| out_valid | output | 1 | Host side: word available |
| out_data | output | DATA_W | Host side: received word |
| out_ready | input | 1 | Host side: word taken |

## Verification
The bench builds the port with DATA_W=8 and ACK_CYCLES=3. The 8-bit width lets a single-mode sweep cover every one of the 256 byte values, with host delays of zero to two cycles. An acknowledge length of three separates the pulse count from the two synchroniser stages, so an off-by-one in either one shows up at a different cycle. Double-mode sessions walk a stride of byte values with the mode flipped mid-session. Directed cases cover a held strobe, edges discarded while a byte waits for the host, and reset inside an armed session.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_PULSE = 2'd1,
        HS_ARMED = 2'd2
    } hs_state_e;
endpackage

// File: rtl/hsp_strobe_sync.sv
module hsp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_async,
    output logic stb_rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[DEPTH-2:0], stb_async};
    end

    // edge of the synchronised strobe: newest synchronised bit high, previous low
    assign stb_rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/hsp_hold.sv
module hsp_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         vld,
    output logic [W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= 1'b0;
            dout <= '0;
        end else if (load) begin
            vld  <= 1'b1;
            dout <= din;
        end else if (vld && ready) begin
            vld  <= 1'b0;
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (vld && !ready && !load) |=> (vld && $stable(dout)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (vld && dout == $past(din)));
endmodule

// File: rtl/hsp_ctrl.sv
module hsp_ctrl
    import hsp_pkg::*;
#(
    parameter int ACK_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic mode_dbl,
    input  logic pend,
    output logic ack,
    output logic load,
    output logic busy
);
    localparam int CW = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(ACK_CYCLES - 1);

    hs_state_e st, st_nx;
    logic [CW-1:0] cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            HS_IDLE:  if (rise && !pend) st_nx = mode_dbl ? HS_ARMED : HS_PULSE;
            HS_PULSE: if (cnt == LAST)   st_nx = HS_IDLE;
            HS_ARMED: if (rise)          st_nx = HS_IDLE;
            default:                     st_nx = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= HS_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst || st != HS_PULSE) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    always_comb begin
        ack  = (st == HS_PULSE) || (st == HS_ARMED);
        load = ((st == HS_IDLE) && rise && !pend && !mode_dbl)
            || ((st == HS_ARMED) && rise);
        busy = (st != HS_IDLE) || pend;
    end

    assert_pend_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        (st == HS_IDLE && pend) |=> (st == HS_IDLE && !ack));

    assert_arm_R5: assert property (@(posedge clk) disable iff (rst)
        (st == HS_IDLE && rise && !pend && mode_dbl) |=> (ack && st == HS_ARMED));

    assert_close_R6: assert property (@(posedge clk) disable iff (rst)
        (st == HS_ARMED && rise) |=> (!ack && busy));

    assert_pulse_mode_R10: assert property (@(posedge clk) disable iff (rst)
        (st == HS_PULSE && cnt != LAST) |=> (st == HS_PULSE && ack));
endmodule

// File: rtl/strobe_ack_rx.sv
module strobe_ack_rx #(
    parameter int DATA_W      = 8,
    parameter int ACK_CYCLES  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_double,
    input  logic              stb_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              ack_out,
    output logic              busy,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    logic rise, load;

    hsp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .stb_async(stb_in), .stb_rise(rise)
    );

    hsp_ctrl #(.ACK_CYCLES(ACK_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .rise(rise), .mode_dbl(mode_double),
        .pend(out_valid), .ack(ack_out), .load(load), .busy(busy)
    );

    hsp_hold #(.W(DATA_W)) u_hold (
        .clk(clk), .rst(rst), .load(load), .din(data_in),
        .ready(out_ready), .vld(out_valid), .dout(out_data)
    );

    assert_busy_pending_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) |-> (!ack_out && !out_valid && !busy));
endmodule

// File: tb/sim_strobe_ack_rx.sv
module sim_strobe_ack_rx;
    localparam int W   = 8;
    localparam int ACK = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_double = 1'b0;
    logic         stb_in = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         out_ready = 1'b0;
    logic         ack_out, busy, out_valid;
    logic [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    strobe_ack_rx #(.DATA_W(W), .ACK_CYCLES(ACK), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .mode_double(mode_double), .stb_in(stb_in),
        .data_in(data_in), .ack_out(ack_out), .busy(busy),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic take_word(input string tag);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk({tag, " valid cleared"}, out_valid, 0);
        chk("R9 busy low when idle", busy, 0);
    endtask

    // single-mode session; hold = cycles the host waits after the pulse
    task automatic single_session(input logic [W-1:0] v, input int hold, input bit flip);
        mode_double = 1'b0;
        data_in = v;
        stb_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 no response before third edge", ack_out, 0);
        @(negedge clk);
        chk("R2/R4 ack at third edge", ack_out, 1);
        chk("R3 valid on capture", out_valid, 1);
        chk("R3 captured word", out_data, v);
        chk("R9 busy in session", busy, 1);
        stb_in = 1'b0;
        data_in = ~v;
        if (flip) mode_double = 1'b1;
        for (int i = 1; i < ACK; i++) begin
            @(negedge clk);
            chk(flip ? "R10 pulse unchanged by mode" : "R4 ack held", ack_out, 1);
        end
        @(negedge clk);
        chk(flip ? "R10 pulse ends on count" : "R4 ack falls after count", ack_out, 0);
        chk("R3 word kept after bus change", out_data, v);
        mode_double = 1'b0;
        for (int i = 0; i < hold; i++) begin
            chk("R7 valid held", out_valid, 1);
            chk("R7 data held", out_data, v);
            chk("R9 busy while pending", busy, 1);
            @(negedge clk);
        end
        take_word("R7");
    endtask

    task automatic double_session(input logic [W-1:0] v, input bit flip);
        mode_double = 1'b1;
        data_in = ~v;
        stb_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R2 double no early ack", ack_out, 0);
        @(negedge clk);
        chk("R5 ready ack", ack_out, 1);
        chk("R5 no valid yet", out_valid, 0);
        chk("R9 busy when armed", busy, 1);
        stb_in = 1'b0;
        if (flip) mode_double = 1'b0;
        data_in = v;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(flip ? "R10 stays armed" : "R5 ack holds", ack_out, 1);
            chk("R5 no valid while armed", out_valid, 0);
        end
        stb_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6 ack before second edge", ack_out, 1);
        @(negedge clk);
        chk("R6 ack dropped", ack_out, 0);
        chk("R6 valid", out_valid, 1);
        chk("R6 sampled word", out_data, v);
        stb_in = 1'b0;
        data_in = ~v;
        mode_double = 1'b1;
        @(negedge clk);
        chk("R7 double word held", out_data, v);
        take_word("R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 ack in reset", ack_out, 0);
        chk("R1 busy in reset", busy, 0);
        chk("R1 valid in reset", out_valid, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // sweep every byte in single mode with host delays 0..2
        for (int v = 0; v < 256; v++) begin
            single_session(W'(v), v % 3, 1'b0);
            @(negedge clk);
        end

        // single mode with the mode input flipped during the pulse
        single_session(8'h5A, 1, 1'b1);
        @(negedge clk);

        // double mode over a stride of values
        for (int v = 0; v < 256; v += 17) begin
            double_session(W'(v), v[0]);
            @(negedge clk);
        end

        // held strobe starts only one session
        mode_double = 1'b0;
        data_in = 8'hC3;
        stb_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 held strobe first session", ack_out, 1);
        repeat (ACK) @(negedge clk);
        take_word("R2");
        repeat (6) begin
            @(negedge clk);
            chk("R2 held strobe no second ack", ack_out, 0);
            chk("R2 held strobe no second word", out_valid, 0);
        end
        stb_in = 1'b0;
        repeat (4) @(negedge clk);

        // strobe edge while a word is pending is discarded
        data_in = 8'h3C;
        stb_in = 1'b1;
        repeat (3) @(negedge clk);
        stb_in = 1'b0;
        repeat (ACK + 2) @(negedge clk);
        data_in = 8'hFF;
        stb_in = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R8 no ack while pending", ack_out, 0);
        end
        stb_in = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R8 word unchanged", out_data, 8'h3C);
            chk("R8 busy while pending", busy, 1);
        end
        take_word("R8");
        repeat (5) begin
            @(negedge clk);
            chk("R8 lost edge starts nothing", ack_out, 0);
            chk("R8 lost edge no word", out_valid, 0);
        end

        // reset inside an armed double session
        mode_double = 1'b1;
        stb_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 armed before reset", ack_out, 1);
        stb_in = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 ack cleared by reset", ack_out, 0);
        chk("R1 busy cleared by reset", busy, 0);
        chk("R1 valid cleared by reset", out_valid, 0);
        repeat (3) @(negedge clk);

        report();
        $finish;
    end
endmodule